// File: doc/BRIEF.md
# Precision Time Clock with Rate Trim and Step Adjust

This block keeps a free-running time of day for a timestamping subsystem. The time has a 32-bit seconds field, a 30-bit nanoseconds field that wraps at one billion, and a 3-bit phase that counts 8 ns core clock cycles since the most recent 40 ns reference tick. On each reference tick, while the clock is enabled, nanoseconds advance by a nominal 40. A 32-bit fractional sub-nanosecond accumulator can stretch or shrink individual ticks by one nanosecond to trim the frequency.

Software never touches the running time directly. It writes or captures a set of shadow registers and then issues single-cycle commands. A capture copies the live time into the shadow. A load copies the shadow into the live time. A step adds the shadow seconds and nanoseconds to the live time, or subtracts them, in one operation. The live time goes out on dedicated outputs so that neighbouring blocks, such as timestampers and trigger units, can use it.

Command inputs are one-cycle strobes, since the register block in front self-clears them. Each result appears on the outputs one clock edge after the cycle in which its command is sampled.

Top module: `ptp_time_clock`

## Requirements
- R1: After reset, the live seconds, nanoseconds and phase are zero, and so are all shadow outputs.
- R2: While `clk_en_i` is low and there is no load or step, the live seconds, nanoseconds and phase hold their values, even when ticks arrive.
- R3: With rate trim off, each tick sampled while enabled adds 40 to nanoseconds. A result of 1,000,000,000 or more wraps by that amount and adds one to seconds.
- R4: While enabled, the phase becomes 0 on a tick cycle. On any other cycle it rises by one, saturating at 7.
- R5: In `rate_word_i`, bit 31 is the direction and bits 29:0 are the magnitude. With bit 31 set and `rate_en_i` high, each tick adds the magnitude to a 32-bit fraction that starts at zero. A carry out makes that tick advance by 41.
- R6: With bit 31 clear and `rate_en_i` high, each tick subtracts the magnitude from the fraction. A borrow makes that tick advance by 39.
- R7: While `rate_en_i` is low, ticks advance by exactly 40 and the fraction keeps its value for later trimmed ticks.
- R8: `cmd_read_i` copies live seconds, nanoseconds and phase into the shadow. When it coincides with a shadow write, the capture wins.
- R9: `sh_wr_i` writes the three shadow fields from the write inputs.
- R10: `cmd_load_i` sets the live time, including phase, to the shadow. This overrides a tick and a step in the same cycle.
- R11: `cmd_step_i` with `step_add_i` high adds the shadow seconds and nanoseconds (nanoseconds below one billion) to the live time, carrying into seconds.
- R12: `cmd_step_i` with `step_add_i` low subtracts them. A nanosecond result below zero borrows one second, and seconds wrap modulo 2^32.
- R13: A step and an enabled tick in the same cycle are both applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, 8 ns |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Time advance enable (level) |
| tick_i | input | 1 | 40 ns reference tick strobe |
| rate_en_i | input | 1 | Rate trim enable (level) |
| rate_word_i | input | 32 | Bit 31 direction (1 faster), bits 29:0 magnitude |
| cmd_read_i | input | 1 | Capture live time into shadow |
| cmd_load_i | input | 1 | Copy shadow into live time |
| cmd_step_i | input | 1 | Apply shadow as a signed step |
| step_add_i | input | 1 | Step direction: 1 add, 0 subtract |
| sh_wr_i | input | 1 | Software shadow write strobe |
| sh_wsec_i | input | 32 | Shadow seconds write data |
| sh_wns_i | input | 30 | Shadow nanoseconds write data |
| sh_wphase_i | input | 3 | Shadow phase write data |
| sh_sec_o | output | 32 | Shadow seconds |
| sh_ns_o | output | 30 | Shadow nanoseconds |
| sh_phase_o | output | 3 | Shadow phase |
| time_sec_o | output | 32 | Live seconds |
| time_ns_o | output | 30 | Live nanoseconds |
| time_phase_o | output | 3 | Live phase in 8 ns units |

## Verification
Every result here sits exactly one register stage behind its cause. A tick, load, step, capture or shadow write sampled at one edge shows up on the outputs right after that edge, and a trimmed tick changes nanoseconds on that same edge. The bench drives inputs a moment after a rising edge, advances one edge and samples a moment later, so each check reads the value due one cycle after its stimulus. The properties relate each command to the outputs at the next edge with `|=>`.

// File: rtl/ptpclk_pkg.sv
package ptpclk_pkg;
    localparam int SEC_W   = 32;
    localparam int NS_W    = 30;
    localparam int PHASE_W = 3;
    localparam int FRAC_W  = 32;
    localparam int MAG_W   = 30;
    localparam int RATE_W  = 32;

    typedef struct packed {
        logic [SEC_W-1:0]   sec;
        logic [NS_W-1:0]    ns;
        logic [PHASE_W-1:0] phase;
    } ptime_t;
endpackage

// File: rtl/ptpclk_rate.sv
module ptpclk_rate
    import ptpclk_pkg::*;
#(
    parameter int NOM_INC = 40
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adv_i,
    input  logic             rate_en_i,
    input  logic             faster_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [NS_W-1:0]  inc_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] frac;
    } rate_st_t;

    rate_st_t        st_d, st_q;
    logic [FRAC_W:0] up_sum;
    logic [FRAC_W:0] dn_diff;

    always_comb begin
        st_d    = st_q;
        up_sum  = {1'b0, st_q.frac} + (FRAC_W+1)'(mag_i);
        dn_diff = {1'b0, st_q.frac} - (FRAC_W+1)'(mag_i);
        inc_o   = NS_W'(NOM_INC);
        if (rate_en_i) begin
            if (faster_i) begin
                if (up_sum[FRAC_W]) inc_o = NS_W'(NOM_INC + 1);
                if (adv_i) st_d.frac = up_sum[FRAC_W-1:0];
            end else begin
                if (dn_diff[FRAC_W]) inc_o = NS_W'(NOM_INC - 1);
                if (adv_i) st_d.frac = dn_diff[FRAC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/ptpclk_norm.sv
module ptpclk_norm
    import ptpclk_pkg::*;
#(
    parameter int NS_ROLL = 1000000000
) (
    input  logic [SEC_W-1:0] sec_i,
    input  logic [NS_W-1:0]  ns_i,
    input  logic [NS_W-1:0]  inc_i,
    input  logic             step_en_i,
    input  logic             step_add_i,
    input  logic [SEC_W-1:0] ssec_i,
    input  logic [NS_W-1:0]  sns_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o
);
    localparam int SUM_W = NS_W + 2;
    localparam logic [SUM_W-1:0] ROLL1 = SUM_W'(NS_ROLL);
    localparam logic [SUM_W-1:0] ROLL2 = SUM_W'(64'(NS_ROLL) * 2);

    logic [SUM_W-1:0] base_ns;
    logic [SUM_W-1:0] step_ns;
    logic [SUM_W-1:0] work;
    logic [SUM_W-1:0] res_ns;
    logic [SEC_W-1:0] step_sec;
    logic [SEC_W-1:0] sec_tmp;
    logic [1:0]       carry_up;
    logic             borrow;
    logic             adding;

    always_comb begin
        base_ns  = SUM_W'(ns_i) + SUM_W'(inc_i);
        step_ns  = step_en_i ? SUM_W'(sns_i) : '0;
        step_sec = step_en_i ? ssec_i : '0;
        adding   = !step_en_i || step_add_i;
        carry_up = 2'd0;
        borrow   = 1'b0;
        work     = '0;
        if (adding) begin
            work = base_ns + step_ns;
            if (work >= ROLL2) begin
                res_ns   = work - ROLL2;
                carry_up = 2'd2;
            end else if (work >= ROLL1) begin
                res_ns   = work - ROLL1;
                carry_up = 2'd1;
            end else begin
                res_ns = work;
            end
        end else if (base_ns >= step_ns) begin
            work = base_ns - step_ns;
            if (work >= ROLL1) begin
                res_ns   = work - ROLL1;
                carry_up = 2'd1;
            end else begin
                res_ns = work;
            end
        end else begin
            res_ns = base_ns + ROLL1 - step_ns;
            borrow = 1'b1;
        end
        sec_tmp = sec_i + SEC_W'(carry_up) - SEC_W'(borrow);
        sec_o   = adding ? (sec_tmp + step_sec) : (sec_tmp - step_sec);
        ns_o    = res_ns[NS_W-1:0];
    end
endmodule

// File: rtl/ptpclk_shadow.sv
module ptpclk_shadow
    import ptpclk_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   cap_i,
    input  ptime_t live_i,
    input  logic   wr_i,
    input  ptime_t wval_i,
    output ptime_t sh_o
);
    ptime_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (cap_i)     sh_d = live_i;
        else if (wr_i) sh_d = wval_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sh_o = sh_q;
endmodule

// File: rtl/ptp_time_clock.sv
module ptp_time_clock
    import ptpclk_pkg::*;
#(
    parameter int NOM_INC = 40,
    parameter int NS_ROLL = 1000000000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clk_en_i,
    input  logic               tick_i,
    input  logic               rate_en_i,
    input  logic [RATE_W-1:0]  rate_word_i,
    input  logic               cmd_read_i,
    input  logic               cmd_load_i,
    input  logic               cmd_step_i,
    input  logic               step_add_i,
    input  logic               sh_wr_i,
    input  logic [SEC_W-1:0]   sh_wsec_i,
    input  logic [NS_W-1:0]    sh_wns_i,
    input  logic [PHASE_W-1:0] sh_wphase_i,
    output logic [SEC_W-1:0]   sh_sec_o,
    output logic [NS_W-1:0]    sh_ns_o,
    output logic [PHASE_W-1:0] sh_phase_o,
    output logic [SEC_W-1:0]   time_sec_o,
    output logic [NS_W-1:0]    time_ns_o,
    output logic [PHASE_W-1:0] time_phase_o
);
    localparam logic [PHASE_W-1:0] PHASE_MAX = {PHASE_W{1'b1}};

    ptime_t           time_d, time_q;
    ptime_t           shadow;
    ptime_t           sw_val;
    logic             advance;
    logic             step_en;
    logic [NS_W-1:0]  rate_inc;
    logic [NS_W-1:0]  tick_inc;
    logic [SEC_W-1:0] norm_sec;
    logic [NS_W-1:0]  norm_ns;

    assign advance  = clk_en_i && tick_i && !cmd_load_i;
    assign step_en  = cmd_step_i && !cmd_load_i;
    assign tick_inc = advance ? rate_inc : '0;
    assign sw_val   = '{sec: sh_wsec_i, ns: sh_wns_i, phase: sh_wphase_i};

    ptpclk_rate #(.NOM_INC(NOM_INC)) i_rate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .adv_i     (advance),
        .rate_en_i (rate_en_i),
        .faster_i  (rate_word_i[RATE_W-1]),
        .mag_i     (rate_word_i[MAG_W-1:0]),
        .inc_o     (rate_inc)
    );

    ptpclk_norm #(.NS_ROLL(NS_ROLL)) i_norm (
        .sec_i      (time_q.sec),
        .ns_i       (time_q.ns),
        .inc_i      (tick_inc),
        .step_en_i  (step_en),
        .step_add_i (step_add_i),
        .ssec_i     (shadow.sec),
        .sns_i      (shadow.ns),
        .sec_o      (norm_sec),
        .ns_o       (norm_ns)
    );

    ptpclk_shadow i_shadow (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cap_i  (cmd_read_i),
        .live_i (time_q),
        .wr_i   (sh_wr_i),
        .wval_i (sw_val),
        .sh_o   (shadow)
    );

    always_comb begin
        time_d = time_q;
        if (cmd_load_i) begin
            time_d = shadow;
        end else begin
            time_d.sec = norm_sec;
            time_d.ns  = norm_ns;
            if (clk_en_i) begin
                if (tick_i)                     time_d.phase = '0;
                else if (time_q.phase != PHASE_MAX) time_d.phase = time_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) time_q <= '0;
        else         time_q <= time_d;
    end

    assign time_sec_o   = time_q.sec;
    assign time_ns_o    = time_q.ns;
    assign time_phase_o = time_q.phase;
    assign sh_sec_o     = shadow.sec;
    assign sh_ns_o      = shadow.ns;
    assign sh_phase_o   = shadow.phase;
endmodule

// File: rtl/ptpclk_chk.sv
module ptpclk_chk
    import ptpclk_pkg::*;
#(
    parameter int NOM_INC = 40,
    parameter int NS_ROLL = 1000000000
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               clk_en_i,
    input logic               tick_i,
    input logic               rate_en_i,
    input logic               cmd_read_i,
    input logic               cmd_load_i,
    input logic               cmd_step_i,
    input logic [SEC_W-1:0]   sh_sec_o,
    input logic [NS_W-1:0]    sh_ns_o,
    input logic [PHASE_W-1:0] sh_phase_o,
    input logic [SEC_W-1:0]   time_sec_o,
    input logic [NS_W-1:0]    time_ns_o,
    input logic [PHASE_W-1:0] time_phase_o
);
    // R3: nanoseconds never reach the rollover value
    a_r3_ns_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(time_ns_o) < 32'(NS_ROLL));

    // R3: untrimmed tick advances by the nominal increment with wrap
    a_r3_nominal_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_i && tick_i && !rate_en_i && !cmd_load_i && !cmd_step_i) |=>
        (32'(time_ns_o) ==
            ((32'($past(time_ns_o)) + 32'(NOM_INC) >= 32'(NS_ROLL))
                ? 32'($past(time_ns_o)) + 32'(NOM_INC) - 32'(NS_ROLL)
                : 32'($past(time_ns_o)) + 32'(NOM_INC))));

    // R2: disabled clock holds its time
    a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clk_en_i && !cmd_load_i && !cmd_step_i) |=>
        ($stable(time_sec_o) && $stable(time_ns_o) && $stable(time_phase_o)));

    // R4: phase clears on an enabled tick
    a_r4_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_i && tick_i && !cmd_load_i) |=> (time_phase_o == '0));

    // R4: phase saturates
    a_r4_phase_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_i && !tick_i && !cmd_load_i && (time_phase_o == {PHASE_W{1'b1}})) |=>
        (time_phase_o == {PHASE_W{1'b1}}));

    // R8: capture copies the live time into the shadow
    a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_read_i |=> (sh_sec_o == $past(time_sec_o) && sh_ns_o == $past(time_ns_o)
                        && sh_phase_o == $past(time_phase_o)));

    // R10: load copies the shadow into the live time
    a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_load_i |=> (time_sec_o == $past(sh_sec_o) && time_ns_o == $past(sh_ns_o)
                        && time_phase_o == $past(sh_phase_o)));
endmodule

bind ptp_time_clock ptpclk_chk #(.NOM_INC(NOM_INC), .NS_ROLL(NS_ROLL)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clk_en_i     (clk_en_i),
    .tick_i       (tick_i),
    .rate_en_i    (rate_en_i),
    .cmd_read_i   (cmd_read_i),
    .cmd_load_i   (cmd_load_i),
    .cmd_step_i   (cmd_step_i),
    .sh_sec_o     (sh_sec_o),
    .sh_ns_o      (sh_ns_o),
    .sh_phase_o   (sh_phase_o),
    .time_sec_o   (time_sec_o),
    .time_ns_o    (time_ns_o),
    .time_phase_o (time_phase_o)
);

// File: tb/test_ptp_time_clock.sv
module test_ptp_time_clock;
    localparam int CLK_PERIOD = 8;

    typedef struct packed {
        logic [31:0] s_sec;
        logic [31:0] s_ns;
        logic [31:0] d_sec;
        logic [31:0] d_ns;
        logic        add;
        logic        tk;
        logic [31:0] e_sec;
        logic [31:0] e_ns;
    } vec_t;

    // start time, step magnitude, direction, tick, expected time
    localparam vec_t VECS [8] = '{
        '{32'd10,  32'd500,       32'd1, 32'd200,       1'b1, 1'b0, 32'd11,         32'd700},
        '{32'd10,  32'd999999900, 32'd0, 32'd150,       1'b1, 1'b0, 32'd11,         32'd50},
        '{32'd10,  32'd100,       32'd2, 32'd300,       1'b0, 1'b0, 32'd7,          32'd999999800},
        '{32'd10,  32'd999999990, 32'd0, 32'd0,         1'b1, 1'b1, 32'd11,         32'd30},
        '{32'd5,   32'd20,        32'd1, 32'd100,       1'b0, 1'b1, 32'd3,          32'd999999960},
        '{32'd3,   32'd999999999, 32'd1, 32'd999999999, 1'b1, 1'b1, 32'd6,          32'd38},
        '{32'd0,   32'd0,         32'd1, 32'd0,         1'b0, 1'b0, 32'hFFFFFFFF,   32'd0},
        '{32'd100, 32'd999999960, 32'd0, 32'd40,        1'b1, 1'b0, 32'd101,        32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0, tick = 1'b0, rate_en = 1'b0;
    logic [31:0] rate_word = '0;
    logic        cmd_read = 1'b0, cmd_load = 1'b0, cmd_step = 1'b0, step_add = 1'b0;
    logic        sh_wr = 1'b0;
    logic [31:0] sh_wsec = '0;
    logic [29:0] sh_wns = '0;
    logic [2:0]  sh_wphase = '0;
    logic [31:0] sh_sec, time_sec;
    logic [29:0] sh_ns, time_ns;
    logic [2:0]  sh_phase, time_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_clock i_ptp_time_clock (
        .clk_i (clk), .rst_ni (rst_n), .clk_en_i (clk_en), .tick_i (tick),
        .rate_en_i (rate_en), .rate_word_i (rate_word),
        .cmd_read_i (cmd_read), .cmd_load_i (cmd_load), .cmd_step_i (cmd_step),
        .step_add_i (step_add), .sh_wr_i (sh_wr), .sh_wsec_i (sh_wsec),
        .sh_wns_i (sh_wns), .sh_wphase_i (sh_wphase),
        .sh_sec_o (sh_sec), .sh_ns_o (sh_ns), .sh_phase_o (sh_phase),
        .time_sec_o (time_sec), .time_ns_o (time_ns), .time_phase_o (time_phase)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clk_en = 1'b0; tick = 1'b0; rate_en = 1'b0; rate_word = '0;
        cmd_read = 1'b0; cmd_load = 1'b0; cmd_step = 1'b0; step_add = 1'b0; sh_wr = 1'b0;
        repeat (2) cyc();
        rst_n = 1'b1;
    endtask

    task automatic sw_write(input logic [31:0] s, input logic [29:0] n, input logic [2:0] p);
        sh_wr = 1'b1; sh_wsec = s; sh_wns = n; sh_wphase = p;
        cyc();
        sh_wr = 1'b0;
    endtask

    task automatic load_time(input logic [31:0] s, input logic [29:0] n);
        sw_write(s, n, 3'd0);
        cmd_load = 1'b1;
        cyc();
        cmd_load = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", "sec", time_sec, 0);
        chk("R1", "ns", time_ns, 0);
        chk("R1", "phase", time_phase, 0);
        chk("R1", "shadow", {sh_sec, sh_ns, sh_phase}, 0);

        // R2 disabled clock ignores ticks
        repeat (3) pulse_tick();
        chk("R2", "ns off", time_ns, 0);
        chk("R2", "phase off", time_phase, 0);

        // R3 / R4 nominal ticks and phase
        clk_en = 1'b1;
        pulse_tick();
        chk("R3", "ns one tick", time_ns, 40);
        chk("R4", "phase at tick", time_phase, 0);
        repeat (3) cyc();
        chk("R4", "phase count", time_phase, 3);
        repeat (6) cyc();
        chk("R4", "phase sat", time_phase, 7);
        clk_en = 1'b0;
        repeat (2) cyc();
        chk("R2", "phase frozen", time_phase, 7);
        chk("R2", "ns frozen", time_ns, 40);
        clk_en = 1'b1;
        pulse_tick();
        chk("R3", "ns two ticks", time_ns, 80);
        chk("R4", "phase cleared", time_phase, 0);
        load_time(32'd7, 30'd999999960);
        pulse_tick();
        chk("R3", "wrap sec", time_sec, 8);
        chk("R3", "wrap ns", time_ns, 0);

        // R5 faster trim: magnitude 0x3FFFFFFF carries on the fifth tick
        do_reset();
        clk_en = 1'b1; rate_en = 1'b1; rate_word = {1'b1, 1'b0, 30'h3FFFFFFF};
        repeat (4) pulse_tick();
        chk("R5", "four ticks", time_ns, 160);
        pulse_tick();
        chk("R5", "carry tick", time_ns, 201);

        // R6 slower trim: borrow on first and fifth tick
        do_reset();
        clk_en = 1'b1; rate_en = 1'b1; rate_word = {1'b0, 1'b0, 30'h3FFFFFFF};
        pulse_tick();
        chk("R6", "borrow tick", time_ns, 39);
        repeat (4) pulse_tick();
        chk("R6", "five ticks", time_ns, 198);

        // R7 trim off: nominal, fraction 0xC0000005 kept
        rate_en = 1'b0;
        repeat (5) pulse_tick();
        chk("R7", "untrimmed", time_ns, 398);
        rate_en = 1'b1;
        pulse_tick();
        chk("R7", "fraction kept", time_ns, 438);
        rate_en = 1'b0;

        // R10 load with phase, R9 shadow write, R8 capture beats write
        clk_en = 1'b0;
        sw_write(32'd42, 30'd123456000, 3'd5);
        cmd_load = 1'b1;
        cyc();
        cmd_load = 1'b0;
        chk("R10", "load sec", time_sec, 42);
        chk("R10", "load ns", time_ns, 123456000);
        chk("R10", "load phase", time_phase, 5);
        sw_write(32'd1, 30'd2, 3'd3);
        chk("R9", "shadow write", {sh_sec, sh_ns, sh_phase}, {32'd1, 30'd2, 3'd3});
        cmd_read = 1'b1; sh_wr = 1'b1; sh_wsec = 32'd9; sh_wns = 30'd9; sh_wphase = 3'd1;
        cyc();
        cmd_read = 1'b0; sh_wr = 1'b0;
        chk("R8", "capture", {sh_sec, sh_ns, sh_phase}, {32'd42, 30'd123456000, 3'd5});

        // R10 load overrides tick and step
        clk_en = 1'b1;
        sw_write(32'd77, 30'd500, 3'd0);
        cmd_load = 1'b1; tick = 1'b1; cmd_step = 1'b1; step_add = 1'b1;
        cyc();
        cmd_load = 1'b0; tick = 1'b0; cmd_step = 1'b0;
        chk("R10", "load wins", {time_sec, time_ns, time_phase}, {32'd77, 30'd500, 3'd0});

        // R11 add, R12 subtract, R13 step with tick: vector walk
        for (int i = 0; i < 8; i++) begin
            string tag;
            tag = VECS[i].tk ? "R13" : (VECS[i].add ? "R11" : "R12");
            load_time(VECS[i].s_sec, VECS[i].s_ns[29:0]);
            sw_write(VECS[i].d_sec, VECS[i].d_ns[29:0], 3'd0);
            cmd_step = 1'b1; step_add = VECS[i].add; tick = VECS[i].tk;
            cyc();
            cmd_step = 1'b0; tick = 1'b0;
            chk(tag, $sformatf("vec %0d sec", i), time_sec, VECS[i].e_sec);
            chk(tag, $sformatf("vec %0d ns", i), time_ns, VECS[i].e_ns);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule